// File: doc/BRIEF.md
# Test Pin Selector with Divider Bypass

This block chooses what a clock synthesizer shows on its single test pin. A 3-bit select code, written into a small register, picks one of eight sources: the serial shift chain output, a constant high or low, the reference clock, the loop counter output, the synthesized output clock, or that output clock divided by four. One code also switches the device into bypass mode. In bypass mode the serial clock replaces the oscillator as the clock that feeds the loop counter and the output divider, and the loop counter output appears on the test pin. Board-level debug can then step the whole divider chain by hand.

All clock-like inputs are treated as level signals and sampled by a fast system clock `clk`. The block holds the loop counter, a switch between the two divider sources that changes only while both are low, a divide-by-four of the output clock, and the output selector. The divider source is brought out on `div_clk` for the downstream output divider. While the parallel load strobe `pload_n` is low, the select register is held at code 000.

Top module: `tpin_select`

## Requirements
- R1: After reset, `test_out`, `bypass` and `div_clk` are 0 and the select code is 000.
- R2: With code 000, `test_out` follows `sr_out`, and each level change shows up no later than four `clk` cycles after it.
- R3: Code 001 drives `test_out` to 1 and code 101 drives it to 0, whatever the other inputs do.
- R4: Code 010 routes `ref_clk` to `test_out`, and code 100 routes `fout_clk` to it.
- R5: Code 111 shows `fout_clk` divided by four. The divider counts rising edges of `fout_clk` from 0 after reset, and the output is 1 after rising edges whose count modulo 4 is 2 or 3.
- R6: Code 011 shows the loop counter output. The counter counts rising edges of its source with modulus M = `loop_mod`, where a value below 2 counts as 2. Its output is 1 for exactly one source period, after rising edges whose number modulo M equals M-1. Outside bypass mode its source is `osc_clk`.
- R7: Code 110 sets `bypass`. The source on `div_clk` and the source of the loop counter become `sclk`, `osc_clk` has no effect on `div_clk`, and `test_out` shows the loop counter output.
- R8: The divider source changes only in a cycle where the sampled levels of `osc_clk` and `sclk` are both 0, so `div_clk` is 0 across a switch. The loop counter restarts at 0 when the source changes.
- R9: While `pload_n` is 0, the select code is forced to 000 and writes through `tsel_wr` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pload_n | input | 1 | Parallel load strobe; low forces the select code to 000 |
| tsel_wr | input | 1 | Write strobe for the select code |
| tsel_din | input | 3 | New select code |
| loop_mod | input | MW (9) | Loop counter modulus M |
| ref_clk | input | 1 | Reference clock level |
| osc_clk | input | 1 | Oscillator clock level (normal divider source) |
| sclk | input | 1 | Serial clock level (divider source in bypass mode) |
| fout_clk | input | 1 | Synthesized output clock level |
| sr_out | input | 1 | Serial shift chain output |
| test_out | output | 1 | Test pin |
| bypass | output | 1 | 1 while the serial clock is the divider source |
| div_clk | output | 1 | Selected divider source clock |

## Verification
The assertions check on every cycle that the select register clears while the load strobe is low, that a source switch happens only with `div_clk` low and both candidate sources low, that the loop counter stays within its modulus and moves only on a source edge or a restart, and that the constant codes drive the pin to the right level. The bench scenarios cover what the assertions do not: the loop counter pulse pattern for several moduli (including a modulus below 2), the divide-by-four sequence, that a pending bypass request waits for a high oscillator level to fall, and that the counter restart on a switch is visible on the pin.

// File: rtl/tpin_pkg.sv
package tpin_pkg;
  typedef enum logic [2:0] {
    TS_SHIFT  = 3'b000,
    TS_HIGH   = 3'b001,
    TS_REF    = 3'b010,
    TS_LOOP   = 3'b011,
    TS_OUT    = 3'b100,
    TS_LOW    = 3'b101,
    TS_BYPASS = 3'b110,
    TS_OUTQ   = 3'b111
  } tsel_e;
endpackage

// File: rtl/tsel_reg.sv
module tsel_reg
  import tpin_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pload_n,
  input  logic       wr,
  input  logic [2:0] din,
  output tsel_e      q
);
  tsel_e q_d;

  always_comb begin
    q_d = q;
    if (!pload_n)  q_d = TS_SHIFT;
    else if (wr)   q_d = tsel_e'(din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= TS_SHIFT;
    else        q <= q_d;
  end

  // R9: a low load strobe clears the code on the next edge
  a_r9_pload_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !pload_n |=> (q == TS_SHIFT));
endmodule

// File: rtl/clk_switch.sv
module clk_switch (
  input  logic clk,
  input  logic rst_n,
  input  logic want_alt,
  input  logic pri_lvl,
  input  logic alt_lvl,
  output logic use_alt,
  output logic src_lvl,
  output logic switching
);
  logic use_alt_d, src_d;

  always_comb begin
    switching = (want_alt != use_alt) && !pri_lvl && !alt_lvl;
    use_alt_d = switching ? want_alt : use_alt;
    src_d     = use_alt ? alt_lvl : pri_lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      use_alt <= 1'b0;
      src_lvl <= 1'b0;
    end else begin
      use_alt <= use_alt_d;
      src_lvl <= src_d;
    end
  end

  // R8: the source never changes while the selected clock is high
  a_r8_switch_low: assert property (@(posedge clk) disable iff (!rst_n)
    (use_alt != $past(use_alt)) |-> !src_lvl);
  a_r8_switch_inputs_low: assert property (@(posedge clk) disable iff (!rst_n)
    (use_alt != $past(use_alt)) |-> (!$past(pri_lvl) && !$past(alt_lvl)));
endmodule

// File: rtl/loop_counter.sv
module loop_counter #(
  parameter int MW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_lvl,
  input  logic          restart,
  input  logic [MW-1:0] modulus,
  output logic          term
);
  localparam logic [MW-1:0] MIN_MOD = MW'(2);

  logic [MW-1:0] cnt_q, cnt_d, mod_eff;
  logic          prev_q, adv;

  always_comb begin
    mod_eff = (modulus < MIN_MOD) ? MIN_MOD : modulus;
    adv     = src_lvl && !prev_q;
    cnt_d   = cnt_q;
    if (restart)                        cnt_d = '0;
    else if (adv && (cnt_q >= mod_eff - MW'(1))) cnt_d = '0;
    else if (adv)                       cnt_d = cnt_q + MW'(1);
    term = (cnt_q == mod_eff - MW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= src_lvl;
    end
  end

  // R6: the count moves only on a source rising edge or a restart
  a_r6_count_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !restart) |=> $stable(cnt_q));
  // R6: with a steady modulus the count stays below it
  a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(modulus) && $past(cnt_q < mod_eff) |-> (cnt_q < mod_eff));
endmodule

// File: rtl/quarter_div.sv
module quarter_div (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic out
);
  logic [1:0] cnt_q, cnt_d;
  logic       prev_q;

  always_comb begin
    cnt_d = cnt_q;
    if (lvl && !prev_q) cnt_d = cnt_q + 2'd1;
    out = cnt_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 2'd0;
      prev_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      prev_q <= lvl;
    end
  end

  // R5: the divided output changes only after an input rising edge
  a_r5_div_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (out != $past(out)) |-> $past(lvl && !prev_q));
endmodule

// File: rtl/tpin_select.sv
module tpin_select
  import tpin_pkg::*;
#(
  parameter int MW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pload_n,
  input  logic          tsel_wr,
  input  logic [2:0]    tsel_din,
  input  logic [MW-1:0] loop_mod,
  input  logic          ref_clk,
  input  logic          osc_clk,
  input  logic          sclk,
  input  logic          fout_clk,
  input  logic          sr_out,
  output logic          test_out,
  output logic          bypass,
  output logic          div_clk
);
  localparam int NLV = 5;

  logic [NLV-1:0] lv_q;
  logic           ref_s, osc_s, sclk_s, fout_s, sr_s;
  tsel_e          code;
  logic           use_alt, src_lvl, switching, term, fq;
  logic           test_d, test_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lv_q <= '0;
    else        lv_q <= {sr_out, fout_clk, sclk, osc_clk, ref_clk};
  end

  assign {sr_s, fout_s, sclk_s, osc_s, ref_s} = lv_q;

  tsel_reg u_tsel (
    .clk(clk), .rst_n(rst_n), .pload_n(pload_n),
    .wr(tsel_wr), .din(tsel_din), .q(code)
  );

  clk_switch u_sw (
    .clk(clk), .rst_n(rst_n), .want_alt(code == TS_BYPASS),
    .pri_lvl(osc_s), .alt_lvl(sclk_s),
    .use_alt(use_alt), .src_lvl(src_lvl), .switching(switching)
  );

  loop_counter #(.MW(MW)) u_loop (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .restart(switching),
    .modulus(loop_mod), .term(term)
  );

  quarter_div u_q4 (
    .clk(clk), .rst_n(rst_n), .lvl(fout_s), .out(fq)
  );

  always_comb begin
    unique case (code)
      TS_SHIFT:  test_d = sr_s;
      TS_HIGH:   test_d = 1'b1;
      TS_REF:    test_d = ref_s;
      TS_LOOP:   test_d = term;
      TS_OUT:    test_d = fout_s;
      TS_LOW:    test_d = 1'b0;
      TS_BYPASS: test_d = term;
      TS_OUTQ:   test_d = fq;
      default:   test_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) test_q <= 1'b0;
    else        test_q <= test_d;
  end

  assign test_out = test_q;
  assign bypass   = use_alt;
  assign div_clk  = src_lvl;

  // R3: constant codes drive the pin one cycle later
  a_r3_const_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code) == TS_HIGH) |-> test_out);
  a_r3_const_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(code) == TS_LOW) |-> !test_out);
  // R7: bypass is only ever taken while the bypass code is selected
  a_r7_bypass_code: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass) |-> ($past(code) == TS_BYPASS));
endmodule

// File: tb/tpin_select_test.sv
module tpin_select_test;
  localparam int MW = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pload_n = 1'b1;
  logic          tsel_wr = 1'b0;
  logic [2:0]    tsel_din = 3'b000;
  logic [MW-1:0] loop_mod = 9'd3;
  logic          ref_clk = 1'b0, osc_clk = 1'b0, sclk = 1'b0;
  logic          fout_clk = 1'b0, sr_out = 1'b0;
  logic          test_out, bypass, div_clk;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  tpin_select #(.MW(MW)) uut (
    .clk(clk), .rst_n(rst_n), .pload_n(pload_n), .tsel_wr(tsel_wr),
    .tsel_din(tsel_din), .loop_mod(loop_mod), .ref_clk(ref_clk),
    .osc_clk(osc_clk), .sclk(sclk), .fout_clk(fout_clk), .sr_out(sr_out),
    .test_out(test_out), .bypass(bypass), .div_clk(div_clk)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    {ref_clk, osc_clk, sclk, fout_clk, sr_out} = '0;
    pload_n = 1'b1;
    tsel_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_code(input logic [2:0] c);
    tsel_din = c;
    tsel_wr  = 1'b1;
    @(negedge clk);
    tsel_wr  = 1'b0;
    hold();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    check("R1 test_out", test_out, 1'b0);
    check("R1 bypass", bypass, 1'b0);
    check("R1 div_clk", div_clk, 1'b0);
    do_reset();
    sr_out = 1'b1;
    hold();
    check("R1 code 000 after reset shows sr_out", test_out, 1'b1);

    // R2 shift output, both levels
    for (int k = 0; k < 4; k++) begin
      sr_out = k[0];
      hold();
      check("R2 sr_out follow", test_out, k[0]);
    end

    // R3 constants, other inputs driven to the opposite level
    sr_out = 1'b0; ref_clk = 1'b0; fout_clk = 1'b0;
    set_code(3'b001);
    check("R3 code 001 high", test_out, 1'b1);
    sr_out = 1'b1; ref_clk = 1'b1; fout_clk = 1'b1;
    set_code(3'b101);
    check("R3 code 101 low", test_out, 1'b0);
    fout_clk = 1'b0; ref_clk = 1'b0; sr_out = 1'b0;

    // R4 reference and output clock routing
    set_code(3'b010);
    for (int k = 0; k < 4; k++) begin
      ref_clk = ~k[0]; fout_clk = k[0];
      hold();
      check("R4 code 010 ref", test_out, ~k[0]);
    end
    set_code(3'b100);
    for (int k = 0; k < 4; k++) begin
      ref_clk = ~k[0]; fout_clk = k[0];
      hold();
      check("R4 code 100 fout", test_out, k[0]);
    end

    // R5 divide by four from a fresh count
    do_reset();
    set_code(3'b111);
    check("R5 fout/4 initial", test_out, 1'b0);
    for (int i = 1; i <= 9; i++) begin
      fout_clk = 1'b1; hold();
      fout_clk = 1'b0; hold();
      check("R5 fout/4", test_out, ((i % 4) >= 2));
    end

    // R6 loop counter on the oscillator, several moduli
    foreach (loop_mod[b]) begin end
    for (int mi = 0; mi < 4; mi++) begin
      int m;
      int eff;
      m   = (mi == 0) ? 1 : (mi == 1) ? 2 : (mi == 2) ? 3 : 5;
      eff = (m < 2) ? 2 : m;
      do_reset();
      loop_mod = MW'(m);
      set_code(3'b011);
      for (int i = 1; i <= 2 * eff + 1; i++) begin
        osc_clk = 1'b1; hold();
        check("R6 div_clk follows osc", div_clk, 1'b1);
        osc_clk = 1'b0; hold();
        check("R6 loop output", test_out, ((i % eff) == eff - 1));
      end
    end

    // R7 bypass: serial clock drives the counter and div_clk
    for (int mi = 0; mi < 3; mi++) begin
      int m;
      m = (mi == 0) ? 0 : (mi == 1) ? 2 : 4;
      do_reset();
      loop_mod = MW'(m);
      set_code(3'b110);
      check("R7 bypass set", bypass, 1'b1);
      osc_clk = 1'b1; hold();
      check("R7 osc ignored in bypass", div_clk, 1'b0);
      osc_clk = 1'b0;
      for (int i = 1; i <= 2 * ((m < 2) ? 2 : m) + 1; i++) begin
        sclk = 1'b1; hold();
        check("R7 div_clk follows sclk", div_clk, 1'b1);
        sclk = 1'b0; hold();
        check("R7 loop output in bypass", test_out,
              ((i % ((m < 2) ? 2 : m)) == ((m < 2) ? 2 : m) - 1));
      end
    end

    // R8 switch waits for a low oscillator and restarts the count
    do_reset();
    loop_mod = 9'd3;
    set_code(3'b011);
    osc_clk = 1'b1; hold();
    osc_clk = 1'b0; hold();
    osc_clk = 1'b1; hold();
    set_code(3'b110);
    check("R8 no switch while osc high", bypass, 1'b0);
    check("R8 div_clk still osc", div_clk, 1'b1);
    osc_clk = 1'b0; hold();
    check("R8 switch after osc low", bypass, 1'b1);
    sclk = 1'b1; hold(); sclk = 1'b0; hold();
    check("R8 count restarted, one edge", test_out, 1'b0);
    sclk = 1'b1; hold(); sclk = 1'b0; hold();
    check("R8 count restarted, terminal", test_out, 1'b1);

    // R9 load strobe clears the code and blocks writes
    set_code(3'b001);
    sr_out = 1'b0;
    pload_n = 1'b0;
    hold();
    check("R9 pload low clears code", test_out, 1'b0);
    check("R9 pload low leaves bypass", bypass, 1'b0);
    set_code(3'b001);
    check("R9 write ignored while pload low", test_out, 1'b0);
    sr_out = 1'b1; hold();
    check("R9 code stays 000", test_out, 1'b1);
    pload_n = 1'b1;
    set_code(3'b101);
    check("R9 writes resume after pload high", test_out, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule